// File: doc/BRIEF.md
# Word Shift-Left Unit with Carry

This unit holds one data word in a register and, when commanded, moves its contents toward the most significant end by a requested number of positions. Zeros enter from the least significant end. A carry flag records the single bit that sat at the shift position before the move. Software-style controllers use it as an execution unit for a shift-with-carry instruction: a value is loaded, a count is presented, and the command input triggers the operation.

Two execution styles are offered. In continuous mode the shift repeats on every clock in which the command level is high. In pulse mode only a low-to-high change of the command starts a shift, so one press gives one shift however long the command stays high. Counts outside 0..15 wrap modulo the word width, and a one-cycle done strobe marks every shift that took place.

Top module: `wsl_unit`

## Requirements
- R1: A synchronous active-high reset clears the word, the carry flag, the done strobe and the command edge history; all three outputs read 0 on the cycle after reset.
- R2: With load_en high, the word register takes load_word on the next clock, the carry flag keeps its value and done stays 0.
- R3: A load takes priority over a shift requested in the same cycle: the loaded value appears unshifted and no done pulse is given.
- R4: A shift places word << n in the word register on the next clock, with the n vacated low bits set to 0.
- R5: On a shift, the carry flag takes bit n of the word as it was before the shift (for example 0xF30F with n = 8 gives 0x0F00 and carry 1).
- R6: The effective shift n is shift_cnt modulo 16, so a count of 18 shifts by 2 and a count of 16 shifts by 0.
- R7: With an effective count of 0 the word is unchanged and the carry takes bit 0.
- R8: With pulse_mode = 1, one shift happens per rising edge of cmd; holding cmd high gives no further shifts until it falls and rises again.
- R9: With pulse_mode = 0, a shift happens on every clock in which cmd is high; with cmd low and no load, the word and carry hold and done is 0.
- R10: done is high for exactly the cycle after each clock in which a shift was performed, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 1 | Command level that requests a shift |
| pulse_mode | input | 1 | 0 = continuous execution, 1 = one shift per rising edge of cmd |
| load_en | input | 1 | Writes load_word into the word register |
| load_word | input | W (16) | Value to load |
| shift_cnt | input | CNT_W (8) | Requested shift count, reduced modulo W |
| word_q | output | W (16) | Registered data word |
| carry_q | output | 1 | Registered carry flag |
| done_q | output | 1 | One-cycle strobe for each performed shift |

## Verification
A wrong shift network or count reduction shows up on word_q and carry_q one clock after the shift command, so each vector is checked at that point. A stuck or uncleared edge-history bit shows as a missing or an extra done pulse in pulse mode, again within one clock of the command rising or staying high. A load that fails to take priority shows as a shifted value and a done pulse in the cycle right after the load.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  typedef enum logic {
    MODE_CONT  = 1'b0,
    MODE_PULSE = 1'b1
  } exec_mode_t;
endpackage

// File: rtl/wsl_trigger.sv
module wsl_trigger
  import wsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd,
  input  exec_mode_t mode,
  output logic       fire
);
  logic cmd_prev;

  always_ff @(posedge clk) begin
    if (rst) cmd_prev <= 1'b0;
    else     cmd_prev <= cmd;
  end

  always_comb begin
    case (mode)
      MODE_PULSE: fire = cmd & ~cmd_prev;
      default:    fire = cmd;
    endcase
  end
endmodule

// File: rtl/wsl_shifter.sv
module wsl_shifter #(
  parameter int W    = 16,
  parameter int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout,
  output logic            bit_out
);
  logic [W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? (stage[k] << STEP) : stage[k];
  end

  assign dout    = stage[SH_W];
  assign bit_out = din[amt];
endmodule

// File: rtl/wsl_unit.sv
module wsl_unit
  import wsl_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             pulse_mode,
  input  logic             load_en,
  input  logic [W-1:0]     load_word,
  input  logic [CNT_W-1:0] shift_cnt,
  output logic [W-1:0]     word_q,
  output logic             carry_q,
  output logic             done_q
);
  localparam int SH_W = $clog2(W);

  exec_mode_t      mode;
  logic            fire;
  logic [SH_W-1:0] eff_cnt;
  logic [W-1:0]    shifted;
  logic            carry_nxt;
  logic [CNT_W-1:0] cnt_mod;

  assign mode    = exec_mode_t'(pulse_mode);
  assign cnt_mod = shift_cnt % CNT_W'(W);
  assign eff_cnt = cnt_mod[SH_W-1:0];

  wsl_trigger u_trig (
    .clk  (clk),
    .rst  (rst),
    .cmd  (cmd),
    .mode (mode),
    .fire (fire)
  );

  wsl_shifter #(.W(W), .SH_W(SH_W)) u_shift (
    .din     (word_q),
    .amt     (eff_cnt),
    .dout    (shifted),
    .bit_out (carry_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      carry_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (load_en) begin
      word_q  <= load_word;
      done_q  <= 1'b0;
    end else if (fire) begin
      word_q  <= shifted;
      carry_q <= carry_nxt;
      done_q  <= 1'b1;
    end else begin
      done_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/wsl_unit_checker.sv
module wsl_unit_checker #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd,
  input logic             pulse_mode,
  input logic             load_en,
  input logic [W-1:0]     load_word,
  input logic [CNT_W-1:0] shift_cnt,
  input logic [W-1:0]     word_q,
  input logic             carry_q,
  input logic             done_q
);
  localparam int SH_W = $clog2(W);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_q == '0 && !carry_q && !done_q)); // R1

  AST_LOAD_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_en)) |-> (carry_q == $past(carry_q))); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_en)) |-> (word_q == $past(load_word) && !done_q)); // R3

  AST_SHIFT_WORD: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (word_q == ($past(word_q) << $past(shift_cnt[SH_W-1:0])))); // R4

  AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (carry_q == $past(word_q[shift_cnt[SH_W-1:0]]))); // R5

  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(pulse_mode) && $past(cmd)
     && $past(cmd, 2)) |-> !done_q); // R8

  AST_CONT_FIRES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_en) && !$past(pulse_mode) && $past(cmd)) |-> done_q); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_en) && !$past(cmd))
      |-> ($stable(word_q) && $stable(carry_q) && !done_q)); // R10
endmodule

bind wsl_unit wsl_unit_checker #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .pulse_mode (pulse_mode),
  .load_en    (load_en),
  .load_word  (load_word),
  .shift_cnt  (shift_cnt),
  .word_q     (word_q),
  .carry_q    (carry_q),
  .done_q     (done_q)
);

// File: tb/wsl_unit_test.sv
module wsl_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd = 1'b0;
  logic        pulse_mode = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_word = '0;
  logic [7:0]  shift_cnt = '0;
  logic [15:0] word_q;
  logic        carry_q;
  logic        done_q;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wsl_unit #(.W(16), .CNT_W(8)) uut (
    .clk(clk), .rst(rst), .cmd(cmd), .pulse_mode(pulse_mode),
    .load_en(load_en), .load_word(load_word), .shift_cnt(shift_cnt),
    .word_q(word_q), .carry_q(carry_q), .done_q(done_q)
  );

  // {initial word, count, expected word, expected carry}
  localparam int NVEC = 8;
  localparam logic [40:0] VEC [NVEC] = '{
    {16'hF30F, 8'd8,   16'h0F00, 1'b1},
    {16'h0001, 8'd18,  16'h0004, 1'b0},
    {16'h8000, 8'd15,  16'h0000, 1'b1},
    {16'hA5A5, 8'd0,   16'hA5A5, 1'b1},
    {16'h1234, 8'd4,   16'h2340, 1'b1},
    {16'h00FF, 8'd16,  16'h00FF, 1'b1},
    {16'h7FFF, 8'd255, 16'h8000, 1'b0},
    {16'h0F0F, 8'd7,   16'h8780, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // set inputs after a falling edge, return at the next falling edge
  task automatic cyc(input logic r, input logic ld, input logic [15:0] lw,
                     input logic c, input logic pm, input logic [7:0] n);
    rst = r; load_en = ld; load_word = lw; cmd = c; pulse_mode = pm; shift_cnt = n;
    @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 16'h0, 0, 0, 0);
    cyc(1, 0, 16'h0, 1, 0, 0);
    // R1 reset state
    chk("R1 word", word_q, 16'h0000);
    chk("R1 carry", {15'b0, carry_q}, 16'h0);
    chk("R1 done", {15'b0, done_q}, 16'h0);

    // table of vectors: R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      cyc(0, 1, VEC[i][40:25], 0, 0, 0);
      cyc(0, 0, 16'h0, 1, 0, VEC[i][24:17]);
      chk("R4/R6/R7 word", word_q, VEC[i][16:1]);
      chk("R5 carry", {15'b0, carry_q}, {15'b0, VEC[i][0]});
      chk("R10 done", {15'b0, done_q}, 16'h1);
    end

    // R9 continuous repeats every cycle
    cyc(0, 1, 16'h0001, 0, 0, 0);
    cyc(0, 0, 16'h0, 1, 0, 8'd1);
    chk("R9 cont 1", word_q, 16'h0002);
    cyc(0, 0, 16'h0, 1, 0, 8'd1);
    chk("R9 cont 2", word_q, 16'h0004);
    cyc(0, 0, 16'h0, 1, 0, 8'd1);
    chk("R9 cont 3", word_q, 16'h0008);
    chk("R10 cont done", {15'b0, done_q}, 16'h1);
    // R9 idle hold
    cyc(0, 0, 16'h0, 0, 0, 8'd3);
    chk("R9 idle word", word_q, 16'h0008);
    chk("R10 idle done", {15'b0, done_q}, 16'h0);

    // R8 pulse mode
    cyc(0, 1, 16'h0001, 0, 1, 0);
    cyc(0, 0, 16'h0, 1, 1, 8'd1);
    chk("R8 first edge", word_q, 16'h0002);
    chk("R10 pulse done", {15'b0, done_q}, 16'h1);
    cyc(0, 0, 16'h0, 1, 1, 8'd1);
    chk("R8 held word", word_q, 16'h0002);
    chk("R8 held done", {15'b0, done_q}, 16'h0);
    cyc(0, 0, 16'h0, 1, 1, 8'd1);
    chk("R8 held again", word_q, 16'h0002);
    cyc(0, 0, 16'h0, 0, 1, 8'd1);
    chk("R8 release", word_q, 16'h0002);
    cyc(0, 0, 16'h0, 1, 1, 8'd1);
    chk("R8 second edge", word_q, 16'h0004);
    chk("R10 second done", {15'b0, done_q}, 16'h1);

    // R2 R3 load keeps carry and wins over shift
    cyc(0, 1, 16'h8000, 0, 0, 0);
    cyc(0, 0, 16'h0, 1, 0, 8'd15);
    chk("R5 carry set", {15'b0, carry_q}, 16'h1);
    cyc(0, 1, 16'h1234, 1, 0, 8'd4);
    chk("R3 load wins", word_q, 16'h1234);
    chk("R3 no done", {15'b0, done_q}, 16'h0);
    chk("R2 carry kept", {15'b0, carry_q}, 16'h1);

    // R1 reset mid-run
    cyc(1, 0, 16'h0, 1, 0, 8'd1);
    chk("R1 mid word", word_q, 16'h0000);
    chk("R1 mid carry", {15'b0, carry_q}, 16'h0);

    finished = 1'b1;
    report();
  end
endmodule